// File: doc/BRIEF.md
# Full-Bridge Gate Decoder with Fault Supervisor

This block turns two logic-level PWM inputs into the four gate-enable signals of one full bridge built from two legs, A and B. Each leg has a high-side and a low-side switch. Two level controls sit above the decode. The run control (active high) releases the outputs when high; when low, every switch is off and the bridge floats. The power-up control (active high) does the same job for standby. A parallel-mode input slaves leg B to leg A, so that the two legs can share the load current. Every change of switch within a leg passes through a programmable dead-time window.

A fault supervisor watches synchronous overcurrent, undervoltage and overvoltage flags and an unsigned die temperature in degrees Celsius. A fault switches every gate off at the same clock edge that samples it. It then latches an active-low fault output. The latch clears only after the run control has been seen low and then high again, and only if no fault condition remains at that time. Thermal shutdown has its own hysteresis and feeds the fault latch. A separate active-low warning flags a lower temperature threshold.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While `run_en` is sampled low, all four gate outputs are 0 after that clock edge, whatever the PWM inputs are.
- R2: While `pwr_up` is sampled low, all four gate outputs are 0 after that clock edge.
- R3: In independent mode with no fault, `pwm_a`/`pwm_b` decode as follows (encoding a,b). 0,0 turns both low-side gates on (passive dump). 1,0 turns on A high and B low (positive drive). 0,1 turns on A low and B high (negative drive).
- R4: In independent mode, the input pair 1,1 turns every gate off. When it is sampled with `run_en` and `pwr_up` high, it sets `illegal_seen`, which then stays 1 until reset.
- R5: When a leg moves from one conducting switch to the other, or turns on from off, both of its gates stay 0 for at least `DEAD_CYC` cycles first. A direct change between its two switches gives exactly `DEAD_CYC` cycles off. Turn-off has no delay.
- R6: An overcurrent, undervoltage or overvoltage flag sampled high forces all gates to 0 and `fault_n` to 0 at that same edge.
- R7: A latched fault holds while `run_en` stays high. It clears at the edge that samples `run_en` high after at least one cycle with `run_en` low. If a fault condition is present at that edge, it re-latches instead.
- R8: `twarn_n` is 0 one cycle after a sample of `temp_c` above `WARN_C` (130), and 1 otherwise.
- R9: Thermal shutdown engages at `temp_c` >= `SD_C` (150) and latches a fault. It releases only after a sample at or below `REL_C` (125). While engaged, it counts as a present fault condition.
- R10: With `parallel_mode` high, leg A is high-side on for `pwm_a`=1 and low-side on for `pwm_a`=0. Leg B copies leg A, `pwm_b` has no effect, and `illegal_seen` is not set.
- R11: After synchronous active-low reset, all gates are 0, `fault_n`=1, `twarn_n`=1, `illegal_seen`=0, and thermal shutdown is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_a | input | 1 | PWM input for leg A |
| pwm_b | input | 1 | PWM input for leg B |
| run_en | input | 1 | High: outputs released; low: all gates off, clears a latched fault on return high |
| pwr_up | input | 1 | High: normal; low: standby with all gates off |
| parallel_mode | input | 1 | High: leg B follows leg A |
| oc_flag | input | 1 | Overcurrent condition |
| uv_flag | input | 1 | Undervoltage condition |
| ov_flag | input | 1 | Overvoltage condition |
| temp_c | input | TEMP_W | Die temperature, unsigned degrees Celsius |
| gate_hi_a | output | 1 | Leg A high-side gate enable |
| gate_lo_a | output | 1 | Leg A low-side gate enable |
| gate_hi_b | output | 1 | Leg B high-side gate enable |
| gate_lo_b | output | 1 | Leg B low-side gate enable |
| fault_n | output | 1 | Latched fault, active low |
| twarn_n | output | 1 | Thermal warning, active low |
| illegal_seen | output | 1 | Sticky flag for the forbidden 1,1 input pair |

## Verification
The bench builds the block with `DEAD_CYC` = 3 rather than the default 2. This widens the off-time counter to two bits and makes an off window of one cycle too short or too long visible at the gate pins. Temperature stays 8 bits wide with the default thresholds, and the random walk is kept between 100 and 160 °C. That range crosses the release, warning and shutdown points many times, so the hysteresis band from 126 to 149 °C is reached both from above and from below, and fault re-latching on a clear attempt inside that band is exercised.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
   typedef enum logic [1:0] {
      LEG_OFF = 2'd0,
      LEG_HI  = 2'd1,
      LEG_LO  = 2'd2
   } leg_state_e;

   localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/hbg_decode.sv
module hbg_decode
   import hbg_pkg::*;
(
   input  logic       pwm_a,
   input  logic       pwm_b,
   input  logic       parallel_mode,
   input  logic       enable,
   output leg_state_e tgt_a,
   output leg_state_e tgt_b
);
   always_comb begin
      tgt_a = LEG_OFF;
      tgt_b = LEG_OFF;
      if (enable) begin
         if (parallel_mode) begin
            tgt_a = pwm_a ? LEG_HI : LEG_LO;
            tgt_b = tgt_a;
         end else begin
            unique case ({pwm_a, pwm_b})
               2'b00: begin tgt_a = LEG_LO;  tgt_b = LEG_LO;  end
               2'b01: begin tgt_a = LEG_LO;  tgt_b = LEG_HI;  end
               2'b10: begin tgt_a = LEG_HI;  tgt_b = LEG_LO;  end
               default: begin tgt_a = LEG_OFF; tgt_b = LEG_OFF; end
            endcase
         end
      end
   end
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
   import hbg_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  leg_state_e target,
   output logic       gate_hi,
   output logic       gate_lo
);
   localparam int unsigned CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
   localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

   initial begin
      if (DEAD_CYC < 1) $error("hbg_leg: DEAD_CYC must be at least 1");
   end

   leg_state_e    cur;
   logic [CW-1:0] off_cnt;
   logic [CW-1:0] off_inc;
   logic          leave;

   assign off_inc = (off_cnt < LAST) ? off_cnt + 1'b1 : off_cnt;
   assign leave   = (target == LEG_OFF) || ((cur != LEG_OFF) && (target != cur));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur     <= LEG_OFF;
         off_cnt <= '0;
      end else if (leave) begin
         off_cnt <= (cur == LEG_OFF) ? off_inc : '0;
         cur     <= LEG_OFF;
      end else if (cur == LEG_OFF) begin
         if (off_cnt >= LAST) cur <= target;
         else off_cnt <= off_inc;
      end
   end

   assign gate_hi = (cur == LEG_HI);
   assign gate_lo = (cur == LEG_LO);
endmodule

// File: rtl/hbg_fault.sv
module hbg_fault #(
   parameter int unsigned TEMP_W = 8,
   parameter int unsigned WARN_C = 130,
   parameter int unsigned SD_C   = 150,
   parameter int unsigned REL_C  = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              oc_flag,
   input  logic              uv_flag,
   input  logic              ov_flag,
   input  logic [TEMP_W-1:0] temp_c,
   output logic              cond_now,
   output logic              fault_q,
   output logic              twarn_q
);
   initial begin
      if (SD_C >= (1 << TEMP_W)) $error("hbg_fault: SD_C does not fit TEMP_W");
      if (REL_C >= SD_C)         $error("hbg_fault: REL_C must be below SD_C");
      if (WARN_C >= SD_C)        $error("hbg_fault: WARN_C must be below SD_C");
   end

   logic hot_now, cool_now, warm_now;
   logic tsd_q, armed_q;

   assign hot_now  = temp_c >= TEMP_W'(SD_C);
   assign cool_now = temp_c <= TEMP_W'(REL_C);
   assign warm_now = temp_c >  TEMP_W'(WARN_C);
   assign cond_now = oc_flag | uv_flag | ov_flag | hot_now | tsd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tsd_q   <= 1'b0;
         fault_q <= 1'b0;
         armed_q <= 1'b0;
         twarn_q <= 1'b0;
      end else begin
         if (hot_now)       tsd_q <= 1'b1;
         else if (cool_now) tsd_q <= 1'b0;
         fault_q <= cond_now | (fault_q & ~(armed_q & run_en));
         armed_q <= fault_q & ~run_en;
         twarn_q <= warm_now;
      end
   end
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
   import hbg_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 2,
   parameter int unsigned TEMP_W   = 8,
   parameter int unsigned WARN_C   = 130,
   parameter int unsigned SD_C     = 150,
   parameter int unsigned REL_C    = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_a,
   input  logic              pwm_b,
   input  logic              run_en,
   input  logic              pwr_up,
   input  logic              parallel_mode,
   input  logic              oc_flag,
   input  logic              uv_flag,
   input  logic              ov_flag,
   input  logic [TEMP_W-1:0] temp_c,
   output logic              gate_hi_a,
   output logic              gate_lo_a,
   output logic              gate_hi_b,
   output logic              gate_lo_b,
   output logic              fault_n,
   output logic              twarn_n,
   output logic              illegal_seen
);
   logic       cond_now, fault_q, twarn_q, enable, illegal_q;
   leg_state_e tgt [NUM_LEGS];
   logic [NUM_LEGS-1:0] hi, lo;

   hbg_fault #(
      .TEMP_W(TEMP_W), .WARN_C(WARN_C), .SD_C(SD_C), .REL_C(REL_C)
   ) u_fault (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .oc_flag(oc_flag), .uv_flag(uv_flag), .ov_flag(ov_flag),
      .temp_c(temp_c), .cond_now(cond_now), .fault_q(fault_q), .twarn_q(twarn_q)
   );

   assign enable = run_en & pwr_up & ~fault_q & ~cond_now;

   hbg_decode u_decode (
      .pwm_a(pwm_a), .pwm_b(pwm_b), .parallel_mode(parallel_mode),
      .enable(enable), .tgt_a(tgt[0]), .tgt_b(tgt[1])
   );

   for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
         .clk(clk), .rst_n(rst_n), .target(tgt[g]),
         .gate_hi(hi[g]), .gate_lo(lo[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) illegal_q <= 1'b0;
      else if (run_en && pwr_up && !parallel_mode && pwm_a && pwm_b) illegal_q <= 1'b1;
   end

   assign gate_hi_a    = hi[0];
   assign gate_lo_a    = lo[0];
   assign gate_hi_b    = hi[1];
   assign gate_lo_b    = lo[1];
   assign fault_n      = ~fault_q;
   assign twarn_n      = ~twarn_q;
   assign illegal_seen = illegal_q;
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
   parameter int unsigned TEMP_W = 8,
   parameter int unsigned WARN_C = 130,
   parameter int unsigned SD_C   = 150
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_en,
   input logic              pwr_up,
   input logic              oc_flag,
   input logic              uv_flag,
   input logic              ov_flag,
   input logic [TEMP_W-1:0] temp_c,
   input logic              gate_hi_a,
   input logic              gate_lo_a,
   input logic              gate_hi_b,
   input logic              gate_lo_b,
   input logic              fault_n,
   input logic              twarn_n,
   input logic              illegal_seen
);
   logic any_gate;
   assign any_gate = gate_hi_a | gate_lo_a | gate_hi_b | gate_lo_b;

   AST_TRISTATE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !run_en |=> !any_gate); // R1
   AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n) !pwr_up |=> !any_gate); // R2
   AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) illegal_seen |=> illegal_seen); // R4
   AST_GAP_A_HI: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_hi_a) |-> $past(!gate_lo_a)); // R5
   AST_GAP_A_LO: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_lo_a) |-> $past(!gate_hi_a)); // R5
   AST_GAP_B_HI: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_hi_b) |-> $past(!gate_lo_b)); // R5
   AST_GAP_B_LO: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_lo_b) |-> $past(!gate_hi_b)); // R5
   AST_FAULT_KILL: assert property (@(posedge clk) disable iff (!rst_n) (oc_flag || uv_flag || ov_flag) |=> (!fault_n && !any_gate)); // R6
   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!fault_n && run_en && $past(run_en)) |=> !fault_n); // R7
   AST_WARN_SET: assert property (@(posedge clk) disable iff (!rst_n) (temp_c > TEMP_W'(WARN_C)) |=> !twarn_n); // R8
   AST_WARN_CLR: assert property (@(posedge clk) disable iff (!rst_n) (temp_c <= TEMP_W'(WARN_C)) |=> twarn_n); // R8
   AST_HOT_TRIP: assert property (@(posedge clk) disable iff (!rst_n) (temp_c >= TEMP_W'(SD_C)) |=> (!fault_n && !any_gate)); // R9
endmodule

bind hbridge_gate_ctrl hbg_checker #(
   .TEMP_W(TEMP_W), .WARN_C(WARN_C), .SD_C(SD_C)
) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwr_up(pwr_up),
   .oc_flag(oc_flag), .uv_flag(uv_flag), .ov_flag(ov_flag), .temp_c(temp_c),
   .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a), .gate_hi_b(gate_hi_b),
   .gate_lo_b(gate_lo_b), .fault_n(fault_n), .twarn_n(twarn_n),
   .illegal_seen(illegal_seen)
);

// File: tb/hbridge_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_bench;
   localparam int DEAD = 3;
   localparam int TW   = 8;
   localparam int S_OFF = 0, S_HI = 1, S_LO = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_a = 0, pwm_b = 0, run_en = 0, pwr_up = 0, parallel_mode = 0;
   logic oc_flag = 0, uv_flag = 0, ov_flag = 0;
   logic [TW-1:0] temp_c = 8'd25;
   logic gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b, fault_n, twarn_n, illegal_seen;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   hbridge_gate_ctrl #(.DEAD_CYC(DEAD), .TEMP_W(TW)) u_hbridge_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .pwm_a(pwm_a), .pwm_b(pwm_b), .run_en(run_en),
      .pwr_up(pwr_up), .parallel_mode(parallel_mode), .oc_flag(oc_flag),
      .uv_flag(uv_flag), .ov_flag(ov_flag), .temp_c(temp_c),
      .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a), .gate_hi_b(gate_hi_b),
      .gate_lo_b(gate_lo_b), .fault_n(fault_n), .twarn_n(twarn_n),
      .illegal_seen(illegal_seen)
   );

   // reference state, built from the requirements
   int m_cur [2];
   int m_cnt [2];
   bit m_fault, m_armed, m_tsd, m_warn, m_ill;

   function automatic void model_reset();
      for (int i = 0; i < 2; i++) begin m_cur[i] = S_OFF; m_cnt[i] = 0; end
      m_fault = 0; m_armed = 0; m_tsd = 0; m_warn = 0; m_ill = 0;
   endfunction

   function automatic void model_step();
      bit hot, cond, en, nf;
      int tgt [2];
      if (!rst_n) begin model_reset(); return; end
      hot  = temp_c >= 150;
      cond = oc_flag | uv_flag | ov_flag | hot | m_tsd;
      en   = run_en & pwr_up & ~m_fault & ~cond;
      tgt[0] = S_OFF; tgt[1] = S_OFF;
      if (en) begin
         if (parallel_mode) begin
            tgt[0] = pwm_a ? S_HI : S_LO; tgt[1] = tgt[0];
         end else begin
            case ({pwm_a, pwm_b})
               2'b00: begin tgt[0] = S_LO; tgt[1] = S_LO; end
               2'b01: begin tgt[0] = S_LO; tgt[1] = S_HI; end
               2'b10: begin tgt[0] = S_HI; tgt[1] = S_LO; end
               default: ;
            endcase
         end
      end
      for (int i = 0; i < 2; i++) begin
         if (tgt[i] == S_OFF || (m_cur[i] != S_OFF && tgt[i] != m_cur[i])) begin
            if (m_cur[i] == S_OFF) begin
               if (m_cnt[i] < DEAD - 1) m_cnt[i]++;
            end else m_cnt[i] = 0;
            m_cur[i] = S_OFF;
         end else if (m_cur[i] == S_OFF) begin
            if (m_cnt[i] >= DEAD - 1) m_cur[i] = tgt[i];
            else m_cnt[i]++;
         end
      end
      if (run_en && pwr_up && !parallel_mode && pwm_a && pwm_b) m_ill = 1;
      nf      = cond | (m_fault & ~(m_armed & run_en));
      m_armed = m_fault & ~run_en;
      m_fault = nf;
      if (hot) m_tsd = 1; else if (temp_c <= 125) m_tsd = 0;
      m_warn = temp_c > 130;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] gates();
      return {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};
   endfunction

   function automatic logic [3:0] m_gates();
      return {m_cur[0] == S_HI, m_cur[0] == S_LO, m_cur[1] == S_HI, m_cur[1] == S_LO};
   endfunction

   task automatic compare_model();
      chk("R3 R5 gates vs model", 32'(gates()), 32'(m_gates()));
      chk("R6 R7 R9 fault_n vs model", 32'(fault_n), 32'(!m_fault));
      chk("R8 twarn_n vs model", 32'(twarn_n), 32'(!m_warn));
      chk("R4 illegal_seen vs model", 32'(illegal_seen), 32'(m_ill));
   endtask

   // inputs already set at a falling edge: advance one cycle and compare
   task automatic tick(int n = 1);
      for (int k = 0; k < n; k++) begin
         model_step();
         @(posedge clk);
         @(negedge clk);
         compare_model();
      end
   endtask

   task automatic toggle_run();
      run_en = 0; tick();
      run_en = 1; tick();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int cnt_off;
      void'($urandom(32'h5EED_1234));
      model_reset();
      @(negedge clk);
      tick(3);
      rst_n = 1;
      // R11: reset state
      chk("R11 gates after reset", 32'(gates()), 0);
      chk("R11 fault_n after reset", 32'(fault_n), 1);
      chk("R11 twarn_n after reset", 32'(twarn_n), 1);
      chk("R11 illegal_seen after reset", 32'(illegal_seen), 0);

      // R2: standby keeps gates off
      run_en = 1; pwm_a = 1; tick(DEAD + 3);
      chk("R2 standby gates", 32'(gates()), 0);

      // R3: positive drive
      pwr_up = 1; tick(DEAD + 2);
      chk("R3 A=1 B=0 positive", 32'(gates()), 32'(4'b1001));
      // R5: reverse, leg A off exactly DEAD cycles
      pwm_a = 0; pwm_b = 1; cnt_off = 0;
      for (int k = 0; k < DEAD + 2; k++) begin
         tick();
         if (!gate_hi_a && !gate_lo_a) cnt_off++;
      end
      chk("R5 dead window length", cnt_off, DEAD);
      chk("R3 A=0 B=1 negative", 32'(gates()), 32'(4'b0110));
      // R3: dump
      pwm_b = 0; tick(DEAD + 2);
      chk("R3 A=0 B=0 dump", 32'(gates()), 32'(4'b0101));

      // R1: three-state low forces off at next edge
      pwm_b = 1; pwm_a = 1; pwm_b = 0; tick(DEAD + 2);
      run_en = 0; tick();
      chk("R1 run low gates off", 32'(gates()), 0);
      run_en = 1; tick(DEAD + 2);

      // R4: illegal pair
      pwm_a = 1; pwm_b = 1; tick();
      chk("R4 illegal pair gates off", 32'(gates()), 0);
      chk("R4 illegal flag set", 32'(illegal_seen), 1);
      pwm_a = 0; pwm_b = 0; tick(DEAD + 2);
      chk("R4 illegal flag sticky", 32'(illegal_seen), 1);

      // R6/R7: overcurrent pulse, hold, clear
      oc_flag = 1; tick(); oc_flag = 0;
      chk("R6 kill on overcurrent", 32'(gates()), 0);
      chk("R6 fault_n low", 32'(fault_n), 0);
      tick(5);
      chk("R7 fault held while run high", 32'(fault_n), 0);
      toggle_run();
      chk("R7 fault cleared by low-high", 32'(fault_n), 1);
      uv_flag = 1; tick(); toggle_run();
      chk("R7 re-latch while undervoltage", 32'(fault_n), 0);
      uv_flag = 0; toggle_run();
      chk("R7 clear after undervoltage gone", 32'(fault_n), 1);

      // R8: warning threshold
      temp_c = 131; tick();
      chk("R8 warn above 130", 32'(twarn_n), 0);
      temp_c = 130; tick();
      chk("R8 no warn at 130", 32'(twarn_n), 1);

      // R9: shutdown with hysteresis
      temp_c = 150; tick();
      chk("R9 trip at 150", 32'(fault_n), 0);
      temp_c = 140; tick(); toggle_run();
      chk("R9 held inside band", 32'(fault_n), 0);
      temp_c = 125; tick(); toggle_run();
      chk("R9 released at 125", 32'(fault_n), 1);

      // R10: parallel mode
      parallel_mode = 1; pwm_a = 1; pwm_b = 0; tick(DEAD + 3);
      chk("R10 parallel high sides", 32'(gates()), 32'(4'b1010));
      pwm_b = 1; tick(2);
      chk("R10 pwm_b ignored", 32'(gates()), 32'(4'b1010));
      pwm_a = 0; tick(DEAD + 3);
      chk("R10 parallel low sides", 32'(gates()), 32'(4'b0101));

      // R11: reset clears sticky flag and thermal state
      temp_c = 140; rst_n = 0; tick(2); rst_n = 1; tick();
      chk("R11 reset clears illegal", 32'(illegal_seen), 0);
      chk("R11 reset releases thermal", 32'(fault_n), 1);
      parallel_mode = 0;

      // constrained random, checked cycle by cycle against the model
      for (int k = 0; k < 4000; k++) begin
         pwm_a = $urandom_range(0, 1);
         if ($urandom_range(0, 3) == 0) pwm_b = $urandom_range(0, 1);
         run_en  = ($urandom_range(0, 19) != 0);
         pwr_up  = ($urandom_range(0, 59) != 0);
         oc_flag = ($urandom_range(0, 79) == 0);
         uv_flag = ($urandom_range(0, 119) == 0);
         ov_flag = ($urandom_range(0, 119) == 0);
         if ($urandom_range(0, 199) == 0) parallel_mode = ~parallel_mode;
         if ($urandom_range(0, 1) == 0) begin
            if ($urandom_range(0, 1) == 0 && temp_c < 160) temp_c = temp_c + 1;
            else if (temp_c > 100) temp_c = temp_c - 1;
         end
         tick(1 + $urandom_range(0, 2));
      end

      summary();
      $finish;
   end
endmodule